// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of one SDRAM read or write burst. A controller loads it with a 9-bit starting column, a 3-bit length code and an ordering select (linear or interleaved). From the following cycle it presents the column for the current beat. It moves to the next beat on every clock where the advance input is high, and it flags the final beat so the controller knows when the burst ends.

A burst can be cut short by the stop input. It can also be replaced by a new load on any cycle, including the last beat of the previous burst, so column commands can be issued back to back. In full-row mode the column runs through all 512 columns of the row and wraps at the end. It keeps going until it is stopped or reloaded. An unsupported length code still gives a single-beat burst, and an error flag is raised for it.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `err_o` are 0 and `col_o` is 0.
- R2: A cycle with `load_i` high makes `valid_o` 1 in the next cycle, with `col_o` equal to the loaded start column (beat 0).
- R3: With `ilv_i`=0 at load, beat n of a burst of length BL = 2^k puts (start + n) mod BL into the low k bits of `col_o`. The bits above those keep the start column's value.
- R4: With `ilv_i`=1 at load, beat n puts (start XOR n) into the low k bits of `col_o`. The bits above those keep the start column's value.
- R5: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. `last_o` is high only on the final beat. Advancing from the final beat makes `valid_o` 0 in the next cycle.
- R6: While `valid_o` is 1 and `adv_i`, `load_i` and `stop_i` are all 0, `col_o`, `last_o` and `valid_o` hold their values.
- R7: Code 3'b111 with `ilv_i`=0 selects a full-row burst. `col_o` increments by one modulo 512 on each advance, `last_o` is never asserted, and the burst continues until it is stopped or reloaded.
- R8: Codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with `ilv_i`=1, give a 1-beat burst with `err_o` high. `err_o` is updated on every load, so the next load with a supported code clears it.
- R9: `stop_i` high without `load_i` makes `valid_o` and `last_o` 0 in the next cycle.
- R10: `load_i` takes priority over `stop_i` and `adv_i`. A load in the middle of a burst restarts at beat 0 of the new burst in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start a new burst from the inputs below |
| start_col_i | input | 9 | Starting column |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = linear order |
| adv_i | input | 1 | Move to the next beat |
| stop_i | input | 1 | End the current burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A burst is active and `col_o` is meaningful |
| last_o | output | 1 | Current beat is the final beat |
| err_o | output | 1 | Last load used an unsupported length code |

## Verification
The checker confirms on every cycle the following: the start column appears one cycle after a load; values hold while the burst is stalled; `valid_o` drops after stop or after the final advance; `last_o` never appears outside a burst or in full-row mode; full-row columns step by one; the bits above a short burst's window stay fixed; and error bursts are one beat long. What the checker cannot show is whether the full linear and interleaved orderings are correct for each length and start offset, or the exact beat count for each code. Those come from the bench's vector table and its directed restart, wraparound and reserved-code scenarios.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

   typedef enum logic [2:0] {
      LEN_ONE  = 3'b000,
      LEN_TWO  = 3'b001,
      LEN_FOUR = 3'b010,
      LEN_EIGHT= 3'b011,
      LEN_ROW  = 3'b111
   } len_code_e;

   typedef struct packed {
      logic       row;    // full-row wrap mode
      logic       bad;    // unsupported code seen
      logic [1:0] lg;     // log2 of burst length for short bursts
   } burst_cfg_t;

   localparam int LEN_CODE_W = 3;
   localparam int MAX_LG     = 3;

endpackage

// File: rtl/bcg_mode_decode.sv
module bcg_mode_decode
   import bcg_pkg::*;
(
   input  logic [LEN_CODE_W-1:0] code_i,
   input  logic                  ilv_i,
   output burst_cfg_t            cfg_o
);

   always_comb begin
      cfg_o = '0;
      case (code_i)
         LEN_ONE:   cfg_o.lg = 2'd0;
         LEN_TWO:   cfg_o.lg = 2'd1;
         LEN_FOUR:  cfg_o.lg = 2'd2;
         LEN_EIGHT: cfg_o.lg = 2'd3;
         LEN_ROW: begin
            if (ilv_i) cfg_o.bad = 1'b1;
            else       cfg_o.row = 1'b1;
         end
         default:   cfg_o.bad = 1'b1;
      endcase
   end

endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             stop_i,
   input  logic             adv_i,
   input  logic             final_i,
   output logic             active_o,
   output logic [CNT_W-1:0] beat_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_o <= 1'b0;
         beat_o   <= '0;
      end else if (load_i) begin
         active_o <= 1'b1;
         beat_o   <= '0;
      end else if (stop_i) begin
         active_o <= 1'b0;
      end else if (active_o && adv_i) begin
         if (final_i) active_o <= 1'b0;
         else         beat_o   <= beat_o + 1'b1;
      end
   end

endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map #(
   parameter int COL_W  = 9,
   parameter bit ILV_EN = 1'b1
) (
   input  logic [COL_W-1:0] start_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] lin_w;
   logic [COL_W-1:0] win_w;

   assign lin_w = start_i + beat_i;

   generate
      if (ILV_EN) begin : g_ilv
         logic [COL_W-1:0] xor_w;
         assign xor_w = start_i ^ beat_i;
         assign win_w = ilv_i ? xor_w : lin_w;
      end else begin : g_lin
         assign win_w = lin_w;
      end
   endgenerate

   generate
      for (genvar i = 0; i < COL_W; i++) begin : g_bit
         assign col_o[i] = mask_i[i] ? win_w[i] : start_i[i];
      end
   endgenerate

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import bcg_pkg::*;
#(
   parameter int COL_W  = 9,
   parameter bit ILV_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic [COL_W-1:0]      start_col_i,
   input  logic [LEN_CODE_W-1:0] len_code_i,
   input  logic                  ilv_i,
   input  logic                  adv_i,
   input  logic                  stop_i,
   output logic [COL_W-1:0]      col_o,
   output logic                  valid_o,
   output logic                  last_o,
   output logic                  err_o
);

   localparam int MAX_BL = 1 << MAX_LG;

   generate
      if (COL_W <= MAX_LG) begin : g_bad_w
         $error("burst_col_gen: COL_W must exceed the short-burst window");
      end
      if (MAX_BL > (1 << COL_W)) begin : g_bad_bl
         $error("burst_col_gen: burst window wider than a row");
      end
   endgenerate

   burst_cfg_t       cfg_d;
   burst_cfg_t       cfg_q;
   logic [COL_W-1:0] start_q;
   logic             ilv_q;
   logic [COL_W-1:0] beat_w;
   logic [COL_W-1:0] mask_w;
   logic             active_w;
   logic             final_w;
   logic             row_q;

   bcg_mode_decode u_dec (
      .code_i (len_code_i),
      .ilv_i  (ilv_i),
      .cfg_o  (cfg_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         start_q <= '0;
         ilv_q   <= 1'b0;
      end else if (load_i) begin
         cfg_q   <= cfg_d;
         start_q <= start_col_i;
         ilv_q   <= ilv_i & ILV_EN;
      end
   end

   assign row_q  = cfg_q.row;
   assign mask_w = row_q ? {COL_W{1'b1}}
                         : COL_W'((1 << cfg_q.lg) - 1);
   assign final_w = !row_q && (beat_w == mask_w);

   bcg_beat_ctr #(.CNT_W(COL_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_i),
      .stop_i   (stop_i),
      .adv_i    (adv_i),
      .final_i  (final_w),
      .active_o (active_w),
      .beat_o   (beat_w)
   );

   bcg_addr_map #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_map (
      .start_i (start_q),
      .beat_i  (beat_w),
      .mask_i  (mask_w),
      .ilv_i   (ilv_q),
      .col_o   (col_o)
   );

   assign valid_o = active_w;
   assign last_o  = active_w && final_w;
   assign err_o   = cfg_q.bad;

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
   parameter int COL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_i,
   input logic             stop_i,
   input logic             adv_i,
   input logic [COL_W-1:0] start_col_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o,
   input logic             err_o,
   input logic             row_q
);

   AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> valid_o && col_o == $past(start_col_i)); // R2

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !adv_i && !load_i && !stop_i |=> valid_o && $stable(col_o) && $stable(last_o)); // R6

   AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i && !load_i |=> !valid_o && !last_o); // R9

   AST_FINAL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && last_o && adv_i && !load_i |=> !valid_o); // R5

   AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o); // R5

   AST_WINDOW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !row_q && adv_i && !load_i && !stop_i && !last_o
      |=> $stable(col_o[COL_W-1:3])); // R3 R4

   AST_ROW_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && row_q |-> !last_o); // R7

   AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && row_q && adv_i && !load_i && !stop_i
      |=> valid_o && col_o == COL_W'($past(col_o) + 1'b1)); // R7

   AST_ERR_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && err_o |-> last_o); // R8

endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .load_i      (load_i),
   .stop_i      (stop_i),
   .adv_i       (adv_i),
   .start_col_i (start_col_i),
   .col_o       (col_o),
   .valid_o     (valid_o),
   .last_o      (last_o),
   .err_o       (err_o),
   .row_q       (row_q)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_i = 1'b0;
   logic [8:0] start_col_i = '0;
   logic [2:0] len_code_i = '0;
   logic       ilv_i = 1'b0;
   logic       adv_i = 1'b0;
   logic       stop_i = 1'b0;
   logic [8:0] col_o;
   logic       valid_o, last_o, err_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   burst_col_gen u_dut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_col_i(start_col_i),
      .len_code_i(len_code_i), .ilv_i(ilv_i), .adv_i(adv_i), .stop_i(stop_i),
      .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
   );

   // vector: start[8:0], code[2:0], ilv, beats[3:0], err
   typedef struct packed {
      logic [8:0] start;
      logic [2:0] code;
      logic       ilv;
      logic [3:0] beats;
      logic       err;
   } vec_t;

   localparam vec_t VECS [11] = '{
      '{9'h000, 3'b000, 1'b0, 4'd1, 1'b0},
      '{9'h005, 3'b001, 1'b0, 4'd2, 1'b0},
      '{9'h00E, 3'b010, 1'b0, 4'd4, 1'b0},
      '{9'h1FD, 3'b011, 1'b0, 4'd8, 1'b0},
      '{9'h00B, 3'b010, 1'b1, 4'd4, 1'b0},
      '{9'h125, 3'b011, 1'b1, 4'd8, 1'b0},
      '{9'h003, 3'b001, 1'b1, 4'd2, 1'b0},
      '{9'h0A7, 3'b100, 1'b0, 4'd1, 1'b1},
      '{9'h0A7, 3'b101, 1'b1, 4'd1, 1'b1},
      '{9'h0A7, 3'b110, 1'b0, 4'd1, 1'b1},
      '{9'h013, 3'b111, 1'b1, 4'd1, 1'b1}
   };

   function automatic logic [8:0] exp_col(logic [8:0] s, int len, logic ilv, int n);
      logic [8:0] m;
      logic [8:0] w;
      m = 9'(len - 1);
      w = ilv ? (s ^ 9'(n)) : 9'(s + 9'(n));
      return (s & ~m) | (w & m);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_load(logic [8:0] s, logic [2:0] c, logic il);
      load_i = 1'b1; start_col_i = s; len_code_i = c; ilv_i = il;
      @(negedge clk);
      load_i = 1'b0;
   endtask

   task automatic run_vec(vec_t v, string req);
      do_load(v.start, v.code, v.ilv);
      adv_i = 1'b1;
      for (int b = 0; b < int'(v.beats); b++) begin
         check(valid_o === 1'b1, {req, " valid"}, valid_o, 1);
         check(col_o === exp_col(v.start, v.beats, v.ilv, b), {req, " col"},
               col_o, exp_col(v.start, v.beats, v.ilv, b));
         check(last_o === (b == int'(v.beats) - 1), {req, " last"}, last_o,
               b == int'(v.beats) - 1);
         check(err_o === v.err, "R8 err", err_o, v.err);
         @(negedge clk);
      end
      check(valid_o === 1'b0, "R5 end", valid_o, 0);
      adv_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(valid_o === 1'b0 && last_o === 1'b0 && err_o === 1'b0 && col_o === 9'h0,
            "R1 reset", {col_o, valid_o, last_o, err_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      foreach (VECS[i]) begin
         run_vec(VECS[i], VECS[i].err ? "R8" : (VECS[i].ilv ? "R4 R5" : "R3 R5"));
      end

      // R8: err cleared by supported load
      do_load(9'h020, 3'b001, 1'b0);
      check(err_o === 1'b0, "R8 clear", err_o, 0);
      check(col_o === 9'h020, "R2 start", col_o, 9'h020);

      // R6 stall
      adv_i = 1'b1; @(negedge clk); adv_i = 1'b0;
      check(col_o === 9'h021 && last_o === 1'b1, "R6 pre", col_o, 9'h021);
      repeat (2) @(negedge clk);
      check(valid_o === 1'b1 && col_o === 9'h021 && last_o === 1'b1, "R6 hold",
            col_o, 9'h021);
      stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;

      // R7 full row wrap, then R9 stop
      do_load(9'h1FE, 3'b111, 1'b0);
      adv_i = 1'b1;
      for (int b = 0; b < 5; b++) begin
         check(valid_o === 1'b1 && col_o === 9'((9'h1FE + b) % 512), "R7 col",
               col_o, (9'h1FE + b) % 512);
         check(last_o === 1'b0, "R7 nolast", last_o, 0);
         @(negedge clk);
      end
      stop_i = 1'b1; @(negedge clk); stop_i = 1'b0; adv_i = 1'b0;
      check(valid_o === 1'b0 && last_o === 1'b0, "R9 stop", valid_o, 0);

      // R10 restart mid burst
      do_load(9'h010, 3'b011, 1'b0);
      adv_i = 1'b1;
      @(negedge clk);
      check(col_o === 9'h011, "R10 pre", col_o, 9'h011);
      load_i = 1'b1; start_col_i = 9'h046; len_code_i = 3'b010; ilv_i = 1'b1;
      stop_i = 1'b1;
      @(negedge clk);
      load_i = 1'b0; stop_i = 1'b0;
      check(valid_o === 1'b1 && col_o === 9'h046, "R10 restart", col_o, 9'h046);
      @(negedge clk);
      check(col_o === 9'h047, "R10 beat1", col_o, 9'h047);
      @(negedge clk);
      check(col_o === 9'h044, "R4 beat2", col_o, 9'h044);
      @(negedge clk);
      check(col_o === 9'h045 && last_o === 1'b1, "R4 beat3", col_o, 9'h045);
      @(negedge clk);
      adv_i = 1'b0;
      check(valid_o === 1'b0, "R5 end", valid_o, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule